// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a dual-slope integrating converter. Each measurement cycle has four phases, always in the same order: auto zero, input integrate, reference deintegrate and integrator output zero, and then the cycle starts again. The block drives one analog switch-select line per phase. It times the integrate window with a counter. During deintegration it counts clocks until a synchronised comparator input shows that the integrator output has crossed zero. The integrate window is fixed, so the deintegrate count is proportional to the input voltage over the reference voltage.

When deintegration ends, the block registers the count as the result and pulses an end-of-conversion strobe for one clock. That strobe also serves as the load strobe for a serial transmit register. A sticky data-ready flag stays set until the reader acknowledges it. If the comparator has not tripped within twice the integrate count, the conversion is overrange: the result saturates to full scale and an overrange flag is raised. The default integrate window is 100 000 clocks, which is 100 ms at 1 MHz and so a whole number of 50 Hz and 60 Hz line periods.

Top module: `dslope_seq`

## Requirements
- R1: While rst_ni is low, sw_az_o is 1, the other three selects are 0, and eoc_o, drdy_o, ovr_o and result_o are all 0.
- R2: Exactly one select output is high in every cycle. The phases follow auto zero → integrate → deintegrate → output zero → auto zero.
- R3: The auto-zero phase lasts AZ_CYC clocks. The integrate phase lasts INT_CYC clocks.
- R4: cmp_i (1 = integrator output has crossed zero) passes through a two-flop synchroniser. The result is the number of deintegrate clocks that come before the first clock in which the synchronised comparator is high. A level on cmp_i driven before deintegrate clock m appears as a result of m+2.
- R5: cmp_i has no effect during auto zero and integrate. Only the first synchronised crossing in a deintegrate phase is used. result_o holds its value between conversion ends.
- R6: If 2*INT_CYC deintegrate clocks pass without a crossing, result_o becomes 2*INT_CYC and ovr_o becomes 1. The next in-range conversion clears ovr_o.
- R7: eoc_o is a one-clock pulse in the first clock after deintegrate ends. The new result_o and ovr_o are valid in that same clock.
- R8: drdy_o is set with eoc_o and stays high until a clock with ack_i high and no eoc_o. If ack_i and eoc_o are high together, the set wins.
- R9: The output-zero phase lasts IZ_CYC clocks. If the synchronised comparator is high once IZ_MIN clocks have passed, the phase ends after IZ_MIN clocks instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator, asynchronous; 1 = zero crossed |
| ack_i | input | 1 | Read acknowledge, clears drdy_o |
| sw_az_o | output | 1 | Auto-zero switch select |
| sw_int_o | output | 1 | Input-integrate switch select |
| sw_dint_o | output | 1 | Reference-deintegrate switch select |
| sw_iz_o | output | 1 | Integrator output-zero switch select |
| result_o | output | RES_W | Latched deintegrate count |
| ovr_o | output | 1 | Last conversion was overrange |
| eoc_o | output | 1 | End-of-conversion / transmit load pulse |
| drdy_o | output | 1 | Sticky data-ready flag |

## Verification
The assertions make no assumption about cmp_i or ack_i. Any pattern is legal, so the phase lengths, the pulse shape and the flag rules must hold under every input. The exact-count checks assume that cmp_i is low during the last two integrate clocks whenever a non-zero result is wanted. The stimulus therefore changes cmp_i only on falling clock edges. It drops cmp_i at the start of integrate, or holds it high from there on for the zero case. It toggles cmp_i freely only in the auto-zero phase, where the comparator must be ignored.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_AZ   = 2'd0,
    PH_INT  = 2'd1,
    PH_DINT = 2'd2,
    PH_IZ   = 2'd3
  } phase_e;

  localparam int unsigned NUM_PH = 4;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int unsigned AZ_CYC  = 1000,
  parameter int unsigned INT_CYC = 100000,
  parameter int unsigned IZ_CYC  = 1000,
  parameter int unsigned IZ_MIN  = 16,
  parameter int unsigned RES_W   = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_s_i,
  output phase_e           phase_o,
  output logic [RES_W-1:0] cnt_o,
  output logic             trip_o,
  output logic             over_o
);
  localparam logic [RES_W-1:0] AZ_LAST   = RES_W'(AZ_CYC - 1);
  localparam logic [RES_W-1:0] INT_LAST  = RES_W'(INT_CYC - 1);
  localparam logic [RES_W-1:0] DINT_LAST = RES_W'(2 * INT_CYC - 1);
  localparam logic [RES_W-1:0] IZ_LAST   = RES_W'(IZ_CYC - 1);
  localparam logic [RES_W-1:0] IZ_FLOOR  = RES_W'(IZ_MIN - 1);

  phase_e           phase_q;
  logic [RES_W-1:0] cnt_q;
  logic             leave;

  assign trip_o = (phase_q == PH_DINT) && cmp_s_i;
  assign over_o = (phase_q == PH_DINT) && !cmp_s_i && (cnt_q == DINT_LAST);

  always_comb begin
    unique case (phase_q)
      PH_AZ:   leave = (cnt_q == AZ_LAST);
      PH_INT:  leave = (cnt_q == INT_LAST);
      PH_DINT: leave = trip_o || over_o;
      default: leave = (cnt_q == IZ_LAST) || (cmp_s_i && (cnt_q >= IZ_FLOOR));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else if (leave) begin
      phase_q <= phase_e'(phase_q + 2'd1);  // IZ wraps to AZ
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int unsigned RES_W = 18,
  parameter int unsigned FULL  = 200000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trip_i,
  input  logic             over_i,
  input  logic [RES_W-1:0] cnt_i,
  input  logic             ack_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             eoc_o,
  output logic             drdy_o
);
  logic done;
  assign done = trip_i || over_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
      eoc_o    <= 1'b0;
      drdy_o   <= 1'b0;
    end else begin
      eoc_o <= done;
      if (trip_i) begin
        result_o <= cnt_i;
        ovr_o    <= 1'b0;
      end else if (over_i) begin
        result_o <= RES_W'(FULL);
        ovr_o    <= 1'b1;
      end
      if (done)       drdy_o <= 1'b1;
      else if (ack_i) drdy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int unsigned AZ_CYC  = 1000,
  parameter int unsigned INT_CYC = 100000,
  parameter int unsigned IZ_CYC  = 1000,
  parameter int unsigned IZ_MIN  = 16,
  parameter int unsigned FULL    = 2 * INT_CYC,
  parameter int unsigned MAX_C   = (FULL > AZ_CYC) ? ((FULL > IZ_CYC) ? FULL : IZ_CYC)
                                                   : ((AZ_CYC > IZ_CYC) ? AZ_CYC : IZ_CYC),
  parameter int unsigned RES_W   = $clog2(MAX_C + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             ack_i,
  output logic             sw_az_o,
  output logic             sw_int_o,
  output logic             sw_dint_o,
  output logic             sw_iz_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             eoc_o,
  output logic             drdy_o
);
  phase_e            phase;
  logic [RES_W-1:0]  cnt;
  logic              cmp_s, trip, over;
  logic [NUM_PH-1:0] sel;

  dslope_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_i), .q_o(cmp_s)
  );

  dslope_fsm #(
    .AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .IZ_CYC(IZ_CYC),
    .IZ_MIN(IZ_MIN), .RES_W(RES_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_s_i(cmp_s),
    .phase_o(phase), .cnt_o(cnt), .trip_o(trip), .over_o(over)
  );

  dslope_result #(.RES_W(RES_W), .FULL(FULL)) u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .trip_i(trip), .over_i(over),
    .cnt_i(cnt), .ack_i(ack_i), .result_o(result_o), .ovr_o(ovr_o),
    .eoc_o(eoc_o), .drdy_o(drdy_o)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_sel
    assign sel[g] = (phase == phase_e'(g));
  end

  assign sw_az_o   = sel[PH_AZ];
  assign sw_int_o  = sel[PH_INT];
  assign sw_dint_o = sel[PH_DINT];
  assign sw_iz_o   = sel[PH_IZ];
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int unsigned AZ_CYC  = 1000,
  parameter int unsigned INT_CYC = 100000,
  parameter int unsigned RES_W   = 18,
  parameter int unsigned FULL    = 200000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             sw_az_o,
  input logic             sw_int_o,
  input logic             sw_dint_o,
  input logic             sw_iz_o,
  input logic [RES_W-1:0] result_o,
  input logic             ovr_o,
  input logic             eoc_o,
  input logic             drdy_o
);
  int unsigned az_run, int_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      az_run  <= 0;
      int_run <= 0;
    end else begin
      az_run  <= sw_az_o  ? az_run + 1  : 0;
      int_run <= sw_int_o ? int_run + 1 : 0;
    end
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sw_az_o, sw_int_o, sw_dint_o, sw_iz_o}) == 1);
  p_az_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_az_o) |-> sw_int_o);
  p_int_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_int_o) |-> sw_dint_o);
  p_dint_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_dint_o) |-> sw_iz_o);
  p_iz_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_iz_o) |-> sw_az_o);
  p_int_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_int_o) |-> int_run == INT_CYC);
  p_az_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_az_o |-> az_run < AZ_CYC);
  p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> $stable(result_o));
  p_ovr_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> result_o == RES_W'(FULL));
  p_eoc_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);
  p_eoc_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_dint_o) |-> eoc_o);
  p_drdy_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> drdy_o);
  p_drdy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o && !ack_i |=> drdy_o);
endmodule

bind dslope_seq dslope_seq_chk #(
  .AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .RES_W(RES_W), .FULL(FULL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i),
  .sw_az_o(sw_az_o), .sw_int_o(sw_int_o), .sw_dint_o(sw_dint_o),
  .sw_iz_o(sw_iz_o), .result_o(result_o), .ovr_o(ovr_o),
  .eoc_o(eoc_o), .drdy_o(drdy_o)
);

// File: tb/dslope_seq_test.sv
module dslope_seq_test;
  localparam int AZ_CYC = 8, INT_CYC = 20, IZ_CYC = 10, IZ_MIN = 3;
  localparam int FULL = 2 * INT_CYC;
  localparam int RES_W = $clog2(FULL + 1);
  localparam int NVEC = 5;
  // deintegrate counts to produce; 0 = comparator high before deintegrate
  localparam int VEC [NVEC] = '{0, 2, 5, 17, FULL - 1};

  logic clk_i = 1'b0, rst_ni = 1'b0, cmp_i = 1'b0, ack_i = 1'b0;
  logic sw_az_o, sw_int_o, sw_dint_o, sw_iz_o, ovr_o, eoc_o, drdy_o;
  logic [RES_W-1:0] result_o;
  int total = 0, bad = 0;
  bit done = 0;

  dslope_seq #(.AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .IZ_CYC(IZ_CYC),
               .IZ_MIN(IZ_MIN)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic tick; @(negedge clk_i); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n >= 0: in-range count n; n < 0: overrange
  task automatic conv(input int n, input bit first, input bit toggle, input bit hold_ack);
    int c, k, prev;
    ack_i = hold_ack;
    while (!sw_az_o) tick;
    prev = int'(result_o);
    c = 0;
    while (sw_az_o) begin
      c++;
      if (toggle) cmp_i = ~cmp_i;
      tick;
    end
    if (!first) check(c == AZ_CYC, "R3 az length", c, AZ_CYC);
    check(sw_int_o, "R2 az->int", int'(sw_int_o), 1);
    cmp_i = (n == 0);
    c = 0;
    while (sw_int_o) begin c++; tick; end
    check(c == INT_CYC, "R3 int length", c, INT_CYC);
    if (toggle) check(int'(result_o) == prev, "R5 result held, cmp ignored", int'(result_o), prev);
    check(sw_dint_o && !sw_az_o && !sw_iz_o, "R2 int->dint", int'(sw_dint_o), 1);
    k = 0;
    if (n >= 2) begin
      repeat (n - 2) tick;
      k = n - 2;
      cmp_i = 1'b1;
    end
    while (!eoc_o && k < 200) begin tick; k++; end
    if (n >= 0) begin
      check(k == n + 1, "R7 eoc timing", k, n + 1);
      check(int'(result_o) == n, "R4 result", int'(result_o), n);
      check(!ovr_o, "R6 ovr clear", int'(ovr_o), 0);
    end else begin
      check(k == FULL, "R6 overrange timing", k, FULL);
      check(int'(result_o) == FULL, "R6 saturate", int'(result_o), FULL);
      check(ovr_o, "R6 ovr set", int'(ovr_o), 1);
    end
    check(drdy_o, "R8 drdy set", int'(drdy_o), 1);
    check(sw_iz_o, "R2 dint->iz", int'(sw_iz_o), 1);
    prev = int'(result_o);
    c = 1;
    tick;
    check(!eoc_o, "R7 eoc one clock", int'(eoc_o), 0);
    check(drdy_o == !hold_ack, "R8 drdy after eoc", int'(drdy_o), int'(!hold_ack));
    if (n >= 0) cmp_i = ~cmp_i;  // extra toggles after the crossing
    if (n >= 0) cmp_i = 1'b1;
    while (sw_iz_o) begin c++; tick; end
    check(c == ((n >= 0) ? IZ_MIN : IZ_CYC), "R9 iz length", c, (n >= 0) ? IZ_MIN : IZ_CYC);
    check(sw_az_o, "R2 iz->az", int'(sw_az_o), 1);
    check(int'(result_o) == prev, "R5 result stable in iz", int'(result_o), prev);
    cmp_i = 1'b0;
    ack_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick;
    check(sw_az_o && !sw_int_o && !sw_dint_o && !sw_iz_o, "R1 selects", int'(sw_az_o), 1);
    check(!eoc_o && !drdy_o && !ovr_o, "R1 flags", int'({eoc_o, drdy_o, ovr_o}), 0);
    check(result_o == '0, "R1 result", int'(result_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) conv(VEC[i], i == 0, 1'b0, 1'b0);

    conv(-1, 1'b0, 1'b0, 1'b0);        // overrange
    conv(5, 1'b0, 1'b1, 1'b0);         // comparator toggled in AZ; clears ovr
    conv(3, 1'b0, 1'b0, 1'b1);         // ack held through eoc: set wins

    // sticky flag and acknowledge
    conv(4, 1'b0, 1'b0, 1'b0);
    repeat (3) tick;
    check(drdy_o, "R8 drdy sticky", int'(drdy_o), 1);
    ack_i = 1'b1;
    tick;
    ack_i = 1'b0;
    check(!drdy_o, "R8 drdy cleared by ack", int'(drdy_o), 0);
    tick;
    check(!drdy_o, "R8 drdy stays clear", int'(drdy_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule